// File: doc/BRIEF.md
# Power-Good and Output-Margining Sequencer

This block decides when a switching regulator may report that its output is good, and steps the output up or down from its nominal level during system test. It watches two window-comparator flags (feedback above the lower good limit, feedback below the upper good limit), a soft-start-complete flag and a global enable. From these it drives an active-high power-good output. When margining is strapped on, two command pins select a raised, lowered or nominal output level. Each change of level is carried out as a timed slew, and the block reports the step direction and a slew-busy flag to the current source that actually moves the output.

A single counter, programmed in clock cycles, takes the place of an external timing capacitor. While power-good is low, the counter measures the long power-good assertion delay. While power-good is high, it measures the much shorter margining slew. A loss of enable or a restart of soft-start returns the whole block to its idle state.

Top module: `pgood_margin_seq`

## Requirements
- R1: While reset is held, pwrGood is 0, marginLevel is nominal (2'b00), marginStep is hold (2'b00) and slewing is 0.
- R2: With enable high and the feedback inside the window, pwrGood stays 0 for PG_DELAY clock edges after ssDone is first sampled high, and rises on the next edge.
- R3: pwrGood never rises while the feedback is outside the window (fbAboveLow and fbBelowHigh not both 1), even after the delay has expired. Once the delay has expired, pwrGood rises on the first edge at which the window is met.
- R4: pwrGood falls after the feedback has been outside the window for FILT_CYC consecutive edges. A shorter excursion leaves pwrGood high. After a fall, the full PG_DELAY delay runs again before pwrGood can rise.
- R5: Command pins decode as {cmdLower,cmdRaise}: 2'b01 requests the raised level (marginLevel 2'b01), 2'b10 requests the lowered level (marginLevel 2'b10), and 2'b00 requests nominal (2'b00).
- R6: Both command pins high is ignored. The previous request is kept and marginLevel does not change.
- R7: A new request starts a slew two edges after it is driven. slewing is then 1 and marginStep shows 2'b01 (toward higher) or 2'b10 (toward lower). marginLevel takes the new value SLEW_CYC+3 edges after the request, and in the same cycle slewing clears and marginStep returns to 2'b00. Slews occur only while pwrGood is 1.
- R8: A request that changes during a slew does not disturb that slew. It is held and starts a new slew on the edge after the running one completes.
- R9: While marginEn is 0 the command pins are disregarded and the request is nominal, so marginLevel settles at or returns to nominal.
- R10: enable low or ssDone low forces, on the next edge, pwrGood to 0, marginLevel to nominal and slewing to 0, and clears the shared counter, so the full delay runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable |
| ssDone | input | 1 | Soft-start ramp complete |
| fbAboveLow | input | 1 | Feedback above the lower good limit |
| fbBelowHigh | input | 1 | Feedback below the upper good limit |
| marginEn | input | 1 | Margining strap |
| cmdLower | input | 1 | Command pin requesting the lowered level |
| cmdRaise | input | 1 | Command pin requesting the raised level |
| pwrGood | output | 1 | Power-good flag, active high |
| marginLevel | output | 2 | Current level: 00 nominal, 01 raised, 10 lowered |
| marginStep | output | 2 | Step direction: 00 hold, 01 up, 10 down |
| slewing | output | 1 | Margining slew in progress |

## Verification
The bench changes inputs on the falling edge and counts rising edges to predict each result. pwrGood is due PG_DELAY+1 edges after soft-start completes, a fall is due FILT_CYC edges after the window is lost, and a disable takes effect one edge later. For margining, slewing is due two edges after a command and the new level is due SLEW_CYC+3 edges after it. A queued request begins one edge after the previous slew ends. Every check samples on the falling edge exactly at the edge count where the value changes, and also one edge earlier, so that both early and late transitions are caught.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [1:0] {
    LVL_NOM = 2'b00,
    LVL_UP  = 2'b01,
    LVL_DN  = 2'b10
  } level_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_t;

  // strobes from control to the shared-timer datapath
  typedef struct packed {
    logic tmrClr;
    logic tmrRun;
    logic useSlew;
    logic fltClr;
    logic fltInc;
  } strobe_t;

  // ordering used to pick a step direction: lowered < nominal < raised
  function automatic logic [1:0] lvlRank(level_t l);
    case (l)
      LVL_DN:  return 2'd0;
      LVL_UP:  return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pgm_datapath.sv
module pgm_datapath
  import pgm_pkg::*;
#(
  parameter int PG_DELAY = 5000,
  parameter int SLEW_CYC = 100,
  parameter int FILT_CYC = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  output logic    tmrDone,
  output logic    fltDone
);

  localparam int MAXC = (PG_DELAY > SLEW_CYC) ? PG_DELAY : SLEW_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] PG_LIM   = TW'(PG_DELAY);
  localparam logic [TW-1:0] SLEW_LIM = TW'(SLEW_CYC);

  logic [TW-1:0] tmr;
  logic [TW-1:0] limit;

  assign limit   = strb.useSlew ? SLEW_LIM : PG_LIM;
  assign tmrDone = (tmr >= limit);

  // shared delay/slew counter, saturating at the selected limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tmr <= '0;
    else if (strb.tmrClr)             tmr <= '0;
    else if (strb.tmrRun && !tmrDone) tmr <= tmr + 1'b1;
  end

  generate
    if (FILT_CYC <= 1) begin : g_noFilt
      assign fltDone = 1'b1;
    end else begin : g_filt
      localparam int FW = $clog2(FILT_CYC);
      localparam logic [FW-1:0] FILT_LAST = FW'(FILT_CYC - 1);
      logic [FW-1:0] fltCnt;
      assign fltDone = (fltCnt == FILT_LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      fltCnt <= '0;
        else if (strb.fltClr)            fltCnt <= '0;
        else if (strb.fltInc && !fltDone) fltCnt <= fltCnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/pgm_control.sv
module pgm_control
  import pgm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    ssDone,
  input  logic    fbAboveLow,
  input  logic    fbBelowHigh,
  input  logic    marginEn,
  input  logic    cmdLower,
  input  logic    cmdRaise,
  input  logic    tmrDone,
  input  logic    fltDone,
  output strobe_t strb,
  output logic    pwrGood,
  output level_t  marginLevel,
  output step_t   marginStep,
  output logic    slewing
);

  level_t level, target, goal, nextTarget;
  logic   pg, slw;
  logic   active, inWin, pgRise, pgFall, keepPg, slewStart, slewEnd;

  assign active = enable && ssDone;
  assign inWin  = fbAboveLow && fbBelowHigh;

  always_comb begin
    nextTarget = target;
    case ({cmdLower, cmdRaise})
      2'b00:   nextTarget = LVL_NOM;
      2'b01:   nextTarget = LVL_UP;
      2'b10:   nextTarget = LVL_DN;
      default: nextTarget = target;
    endcase
    if (!marginEn) nextTarget = LVL_NOM;
  end

  assign pgRise    = active && !pg && tmrDone && inWin;
  assign pgFall    = active && pg && !inWin && fltDone;
  assign keepPg    = active && pg && !pgFall;
  assign slewStart = keepPg && !slw && (target != level);
  assign slewEnd   = keepPg && slw && tmrDone;

  always_comb begin
    strb.useSlew = pg;
    strb.tmrRun  = active && (!pg || slw);
    strb.tmrClr  = !active || pgRise || pgFall || slewStart || slewEnd;
    strb.fltInc  = active && pg && !inWin;
    strb.fltClr  = !(active && pg && !inWin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg <= 1'b0; slw <= 1'b0;
      level <= LVL_NOM; target <= LVL_NOM; goal <= LVL_NOM;
    end else if (!active) begin
      pg <= 1'b0; slw <= 1'b0;
      level <= LVL_NOM; target <= LVL_NOM; goal <= LVL_NOM;
    end else begin
      target <= nextTarget;
      if (pgRise) pg <= 1'b1;
      if (pgFall) begin
        pg  <= 1'b0;
        slw <= 1'b0;
      end
      if (slewStart) begin
        slw  <= 1'b1;
        goal <= target;
      end
      if (slewEnd) begin
        level <= goal;
        slw   <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!slw)                             marginStep = STEP_HOLD;
    else if (lvlRank(goal) > lvlRank(level)) marginStep = STEP_UP;
    else                                  marginStep = STEP_DN;
  end

  assign pwrGood     = pg;
  assign marginLevel = level;
  assign slewing     = slw;

endmodule

// File: rtl/pgood_margin_seq.sv
module pgood_margin_seq
  import pgm_pkg::*;
#(
  parameter int PG_DELAY = 5000,
  parameter int SLEW_CYC = 100,
  parameter int FILT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ssDone,
  input  logic       fbAboveLow,
  input  logic       fbBelowHigh,
  input  logic       marginEn,
  input  logic       cmdLower,
  input  logic       cmdRaise,
  output logic       pwrGood,
  output logic [1:0] marginLevel,
  output logic [1:0] marginStep,
  output logic       slewing
);

  strobe_t strb;
  logic    tmrDone, fltDone;
  level_t  lvl;
  step_t   stp;

  pgm_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ssDone(ssDone),
    .fbAboveLow(fbAboveLow), .fbBelowHigh(fbBelowHigh), .marginEn(marginEn),
    .cmdLower(cmdLower), .cmdRaise(cmdRaise), .tmrDone(tmrDone),
    .fltDone(fltDone), .strb(strb), .pwrGood(pwrGood), .marginLevel(lvl),
    .marginStep(stp), .slewing(slewing)
  );

  pgm_datapath #(.PG_DELAY(PG_DELAY), .SLEW_CYC(SLEW_CYC), .FILT_CYC(FILT_CYC)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .tmrDone(tmrDone), .fltDone(fltDone)
  );

  assign marginLevel = lvl;
  assign marginStep  = stp;

endmodule

// File: rtl/pgm_checker.sv
module pgm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       ssDone,
  input logic       fbAboveLow,
  input logic       fbBelowHigh,
  input logic       marginEn,
  input logic       pwrGood,
  input logic [1:0] marginLevel,
  input logic [1:0] marginStep,
  input logic       slewing
);

  // R2
  pg_rise_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrGood) |-> $past(enable && ssDone && fbAboveLow && fbBelowHigh));

  // R4
  pg_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwrGood) && $past(enable && ssDone)) |-> $past(!(fbAboveLow && fbBelowHigh)));

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && ssDone) |=> (!pwrGood && marginLevel == 2'b00 && !slewing));

  // R7
  slew_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slewing |-> pwrGood);

  // R7
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(marginStep) && (slewing || marginStep == 2'b00));

  // R7
  level_via_slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((marginLevel != $past(marginLevel)) && $past(enable && ssDone)) |-> ($past(slewing) && !slewing));

  // R5
  level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    marginLevel != 2'b11);

  // R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!marginEn && marginLevel == 2'b00) |=> (marginLevel == 2'b00));

endmodule

bind pgood_margin_seq pgm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ssDone(ssDone),
  .fbAboveLow(fbAboveLow), .fbBelowHigh(fbBelowHigh), .marginEn(marginEn),
  .pwrGood(pwrGood), .marginLevel(marginLevel), .marginStep(marginStep),
  .slewing(slewing)
);

// File: tb/tb_pgood_margin_seq.sv
module tb_pgood_margin_seq;

  localparam int PG   = 60;
  localparam int SLEW = 12;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rst_n, enable, ssDone, fbAboveLow, fbBelowHigh, marginEn, cmdLower, cmdRaise;
  logic pwrGood, slewing;
  logic [1:0] marginLevel, marginStep;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pgood_margin_seq #(.PG_DELAY(PG), .SLEW_CYC(SLEW), .FILT_CYC(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ssDone(ssDone),
    .fbAboveLow(fbAboveLow), .fbBelowHigh(fbBelowHigh), .marginEn(marginEn),
    .cmdLower(cmdLower), .cmdRaise(cmdRaise), .pwrGood(pwrGood),
    .marginLevel(marginLevel), .marginStep(marginStep), .slewing(slewing)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 0; ssDone = 0; fbAboveLow = 0; fbBelowHigh = 0;
    marginEn = 0; cmdLower = 0; cmdRaise = 0;
    tick(3);
    check("R1", "pwrGood", int'(pwrGood), 0);
    check("R1", "level", int'(marginLevel), 0);
    check("R1", "step", int'(marginStep), 0);
    check("R1", "slewing", int'(slewing), 0);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_powerUp();
    enable = 1; fbAboveLow = 1; fbBelowHigh = 1; marginEn = 1; ssDone = 1;
    tick(PG);
    check("R2", "pwrGood before delay", int'(pwrGood), 0);
    tick(1);
    check("R2", "pwrGood after delay", int'(pwrGood), 1);
  endtask

  task automatic t_filter();
    fbBelowHigh = 0;
    tick(FILT - 1);
    fbBelowHigh = 1;
    tick(1);
    check("R4", "short excursion", int'(pwrGood), 1);
    fbBelowHigh = 0;
    tick(FILT - 1);
    check("R4", "before filter", int'(pwrGood), 1);
    tick(1);
    check("R4", "after filter", int'(pwrGood), 0);
    fbBelowHigh = 1;
    tick(PG);
    check("R4", "redelay pending", int'(pwrGood), 0);
    tick(1);
    check("R4", "redelay done", int'(pwrGood), 1);
  endtask

  task automatic t_margin();
    cmdRaise = 1;
    tick(1);
    check("R7", "slew not yet", int'(slewing), 0);
    tick(1);
    check("R7", "slew started", int'(slewing), 1);
    check("R7", "step up", int'(marginStep), 1);
    tick(SLEW);
    check("R7", "still slewing", int'(slewing), 1);
    check("R7", "level held in slew", int'(marginLevel), 0);
    tick(1);
    check("R5", "raised level", int'(marginLevel), 1);
    check("R7", "slew ended", int'(slewing), 0);
    check("R7", "step hold", int'(marginStep), 0);
  endtask

  task automatic t_ignore();
    cmdLower = 1; cmdRaise = 1;
    tick(SLEW + 5);
    check("R6", "both high level", int'(marginLevel), 1);
    check("R6", "both high slewing", int'(slewing), 0);
  endtask

  task automatic t_queue();
    cmdLower = 1; cmdRaise = 0;
    tick(2);
    check("R8", "first slew on", int'(slewing), 1);
    check("R8", "step down", int'(marginStep), 2);
    tick(2);
    cmdLower = 0;
    tick(SLEW - 1);
    check("R5", "lowered level", int'(marginLevel), 2);
    tick(1);
    check("R8", "queued slew on", int'(slewing), 1);
    check("R8", "queued step up", int'(marginStep), 1);
    tick(SLEW);
    check("R8", "queued still slewing", int'(slewing), 1);
    tick(1);
    check("R8", "queued nominal", int'(marginLevel), 0);
  endtask

  task automatic t_strap();
    marginEn = 0; cmdRaise = 1;
    tick(SLEW + 5);
    check("R9", "strap off level", int'(marginLevel), 0);
    check("R9", "strap off slewing", int'(slewing), 0);
    marginEn = 1;
    tick(SLEW + 3);
    check("R9", "strap on raised", int'(marginLevel), 1);
    marginEn = 0;
    tick(SLEW + 2);
    check("R9", "return pending", int'(marginLevel), 1);
    tick(1);
    check("R9", "returned nominal", int'(marginLevel), 0);
  endtask

  task automatic t_disable();
    marginEn = 1;
    tick(SLEW + 3);
    check("R10", "raised before off", int'(marginLevel), 1);
    enable = 0;
    tick(1);
    check("R10", "off pwrGood", int'(pwrGood), 0);
    check("R10", "off level", int'(marginLevel), 0);
    enable = 1;
    tick(PG);
    check("R10", "re-enable pending", int'(pwrGood), 0);
    tick(1);
    check("R10", "re-enable done", int'(pwrGood), 1);
    tick(3);
    check("R10", "slewing before restart", int'(slewing), 1);
    ssDone = 0; cmdRaise = 0;
    tick(1);
    check("R10", "restart pwrGood", int'(pwrGood), 0);
    check("R10", "restart slewing", int'(slewing), 0);
    check("R10", "restart level", int'(marginLevel), 0);
    ssDone = 1;
    tick(PG);
    check("R10", "restart pending", int'(pwrGood), 0);
    tick(1);
    check("R10", "restart done", int'(pwrGood), 1);
  endtask

  task automatic t_window();
    ssDone = 0;
    tick(1);
    fbAboveLow = 0; ssDone = 1;
    tick(PG + 3);
    check("R3", "outside window", int'(pwrGood), 0);
    fbAboveLow = 1;
    tick(1);
    check("R3", "window met", int'(pwrGood), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerUp();
    t_filter();
    t_margin();
    t_ignore();
    t_queue();
    t_strap();
    t_disable();
    t_window();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule